// File: doc/BRIEF.md
# Memory Bitfield Read-Modify-Write Engine

This block runs one bitfield operation on a field held in byte-addressed memory. The field is 1 to 32 bits wide. It starts at any bit position that lies a byte address plus a bit offset away, so it may straddle up to five bytes. The block takes a base address, a bit offset, a width code, an operation code and a source word. It then fetches every byte the field touches through a memory port that moves one byte per cycle. The bytes are packed most-significant first into a 64-bit working window.

From the window the engine extracts the field and derives a negative flag and a zero flag. The test, extract and find-first-one operations return their answer on a result port and leave memory alone. The change, clear, set and insert operations edit only the field bits inside the window. They then store the touched bytes back, in the same order and to the same addresses. A caller pulses `start`, waits while `busy` is high, and reads `result` and the flags when `done` pulses.

The memory port is combinational on reads: `mem_rdata` must reflect `mem_addr` in the same cycle that `mem_rd` is high. The byte is captured at the end of that cycle.

Top module: `bitfield_rmw_engine`

## Requirements
- R1: On `start`, the first byte accessed is `base_addr + (bit_offset >> 3)`. Later reads, and later writes, step the address up by one per access. Only `bit_offset[2:0]` serves as the bit position inside that first byte, with 0 being the byte's most significant bit.
- R2: The engine reads exactly `(bit_offset[2:0] + W + 7) >> 3` bytes, where W is the field width. A `width_code` of 0 means W = 32; any other code means W = `width_code`.
- R3: Operation 1 (unsigned extract) returns the field zero-extended and right-aligned on `result`.
- R4: Operation 3 (signed extract) returns the field sign-extended from its top bit on `result`.
- R5: Operation 5 (find first one) returns `bit_offset[2:0]` plus the index of the first set bit in the field, counted from the field's most significant bit. If the field is all zero, the index is W.
- R6: For every operation, `flag_n` equals the field's most significant bit and `flag_z` is 1 exactly when the field is zero. Both are taken before any modification.
- R7: Operations 2 (invert), 4 (clear) and 6 (set) invert, clear or set exactly the field bits. All other bits of the touched bytes are written back unchanged, to the same addresses and in the same order as they were read.
- R8: Operation 7 (insert) replaces the field with the low W bits of `src_data`, most significant bit first, and leaves the neighbouring bits as they were.
- R9: Operations 0 (test), 1, 3 and 5 never raise `mem_wr`. On these operations, and on operations 2 and 4, `result` is 0 except for the operations defined above. Operations 0, 2, 4, 6 and 7 return 0.
- R10: `busy` stays high from the cycle after `start` until the `done` pulse, inclusive. `done` is high for exactly one cycle, after the last byte access. A `start` raised while `busy` is high is ignored.
- R11: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| op_sel | input | 3 | Operation code, see R3 to R9 |
| base_addr | input | ADDR_W | Byte address the bit offset counts from |
| bit_offset | input | OFS_W | Bit offset of the field's top bit |
| width_code | input | 5 | Field width, with 0 meaning 32 |
| src_data | input | 32 | Value to insert (operation 7) |
| mem_addr | output | ADDR_W | Byte address of the current access |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte being stored |
| mem_rdata | input | 8 | Byte read from `mem_addr` in the same cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Register result, held after `done` |
| flag_n | output | 1 | Field's top bit |
| flag_z | output | 1 | Field is zero |

## Verification
The bench targets these cases:
- Fields that end exactly on a byte boundary. An off-by-one byte count there either fetches a spurious fifth byte or drops the last one.
- Full 32-bit fields at bit position 7, which touch five bytes. A narrow window or a wrong shift would lose the tail bits.
- Width code 0. If it were not read as 32, the field would collapse to nothing.
- Large bit offsets, which test whether the address is advanced by whole bytes.
- An all-zero field under find-first-one, which must return the offset plus the width and not a stray index.
- Negative fields under signed extract.
- A second `start` in mid-run. A design that accepted it would return the wrong result and touch the wrong bytes.

Whole-memory comparison after every operation exposes masks that spill onto neighbouring bits.

// File: rtl/bfe_pkg.sv
package bfe_pkg;
  localparam int WIN_W   = 64;
  localparam int FLD_W   = 32;
  localparam int BYTE_W  = 8;
  localparam int IDX_W   = 3;
  localparam int WID_W   = 6;
  localparam int POS_W   = 3;

  typedef enum logic [2:0] {
    OP_TEST  = 3'd0,
    OP_XU    = 3'd1,
    OP_FLIP  = 3'd2,
    OP_XS    = 3'd3,
    OP_CLEAR = 3'd4,
    OP_FFO   = 3'd5,
    OP_FILL  = 3'd6,
    OP_PUT   = 3'd7
  } bf_op_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_READ  = 3'd1,
    S_CALC  = 3'd2,
    S_WRITE = 3'd3,
    S_FIN   = 3'd4
  } seq_state_e;

  function automatic logic op_writes(bf_op_e o);
    return (o == OP_FLIP) || (o == OP_CLEAR) || (o == OP_FILL) || (o == OP_PUT);
  endfunction
endpackage

// File: rtl/bfe_seq.sv
module bfe_seq
  import bfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] nbytes,
  input  logic             writes,
  output logic             load,
  output logic             rd_en,
  output logic             wr_en,
  output logic             update,
  output logic             done,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);
  seq_state_e       state_q, state_nx;
  logic [IDX_W-1:0] idx_q, idx_nx;
  logic             last;

  assign last = (idx_q == nbytes - IDX_W'(1));

  always_comb begin
    state_nx = state_q;
    idx_nx   = idx_q;
    load     = 1'b0;
    rd_en    = 1'b0;
    wr_en    = 1'b0;
    update   = 1'b0;
    done     = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          load     = 1'b1;
          idx_nx   = '0;
          state_nx = S_READ;
        end
      end
      S_READ: begin
        rd_en = 1'b1;
        if (last) begin
          idx_nx   = '0;
          state_nx = S_CALC;
        end else begin
          idx_nx = idx_q + IDX_W'(1);
        end
      end
      S_CALC: begin
        update   = 1'b1;
        state_nx = writes ? S_WRITE : S_FIN;
      end
      S_WRITE: begin
        wr_en = 1'b1;
        if (last) begin
          idx_nx   = '0;
          state_nx = S_FIN;
        end else begin
          idx_nx = idx_q + IDX_W'(1);
        end
      end
      S_FIN: begin
        done     = 1'b1;
        state_nx = S_IDLE;
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_nx;
      idx_q   <= idx_nx;
    end
  end

  assign busy = (state_q != S_IDLE);
  assign idx  = idx_q;
endmodule

// File: rtl/bfe_window.sv
module bfe_window
  import bfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap_en,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] rbyte,
  input  logic [WIN_W-1:0]  new_win,
  output logic [WIN_W-1:0]  win,
  output logic [BYTE_W-1:0] wbyte
);
  logic [WIN_W-1:0] win_q, win_nx;
  logic             win_en;

  assign win_en = clear | cap_en | upd_en;

  always_comb begin
    win_nx = win_q;
    if (clear) begin
      win_nx = '0;
    end else if (cap_en) begin
      win_nx[WIN_W-1-BYTE_W*int'(idx) -: BYTE_W] = rbyte;
    end else if (upd_en) begin
      win_nx = new_win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (win_en) begin
      win_q <= win_nx;
    end
  end

  assign win   = win_q;
  assign wbyte = win_q[WIN_W-1-BYTE_W*int'(idx) -: BYTE_W];
endmodule

// File: rtl/bfe_alu.sv
module bfe_alu
  import bfe_pkg::*;
(
  input  logic [WIN_W-1:0] win,
  input  logic [POS_W-1:0] bitoff,
  input  logic [WID_W-1:0] wid,
  input  bf_op_e           op,
  input  logic [FLD_W-1:0] src,
  output logic [WIN_W-1:0] new_win,
  output logic [FLD_W-1:0] res,
  output logic             neg,
  output logic             zero
);
  logic [WIN_W-1:0] shifted;
  logic [FLD_W-1:0] lmask;
  logic [FLD_W-1:0] field;
  logic [WIN_W-1:0] low_ones;
  logic [6:0]       place;
  logic [WIN_W-1:0] wmask;
  logic [WIN_W-1:0] ins_bits;
  logic [WID_W-1:0] rshift;
  logic [WID_W-1:0] ffo_pos;
  logic             ffo_hit;

  assign shifted  = win << bitoff;
  assign lmask    = {FLD_W{1'b1}} << (WID_W'(FLD_W) - wid);
  assign field    = shifted[WIN_W-1 -: FLD_W] & lmask;
  assign low_ones = (WIN_W'(1) << wid) - WIN_W'(1);
  assign place    = 7'(WIN_W) - 7'(bitoff) - 7'(wid);
  assign wmask    = low_ones << place;
  assign ins_bits = ({{(WIN_W-FLD_W){1'b0}}, src} & low_ones) << place;
  assign rshift   = WID_W'(FLD_W) - wid;
  assign neg      = field[FLD_W-1];
  assign zero     = (field == '0);

  always_comb begin
    ffo_pos = wid;
    ffo_hit = 1'b0;
    for (int i = 0; i < FLD_W; i++) begin
      if (!ffo_hit && (WID_W'(i) < wid) && field[FLD_W-1-i]) begin
        ffo_pos = WID_W'(i);
        ffo_hit = 1'b1;
      end
    end
  end

  always_comb begin
    res     = '0;
    new_win = win;
    unique case (op)
      OP_XU:    res = field >> rshift;
      OP_XS:    res = $unsigned($signed(field) >>> rshift);
      OP_FFO:   res = FLD_W'(bitoff) + FLD_W'(ffo_pos);
      OP_FLIP:  new_win = win ^ wmask;
      OP_CLEAR: new_win = win & ~wmask;
      OP_FILL:  new_win = win | wmask;
      OP_PUT:   new_win = (win & ~wmask) | ins_bits;
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/bitfield_rmw_engine.sv
module bitfield_rmw_engine
  import bfe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op_sel,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFS_W-1:0]  bit_offset,
  input  logic [4:0]        width_code,
  input  logic [31:0]       src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       result,
  output logic              flag_n,
  output logic              flag_z
);
  localparam int BYTE_SKIP_W = (OFS_W > 3) ? OFS_W - 3 : 1;

  logic [ADDR_W-1:0] addr_q;
  logic [POS_W-1:0]  bitoff_q;
  logic [WID_W-1:0]  wid_q;
  bf_op_e            op_q;
  logic [FLD_W-1:0]  src_q;
  logic              op_wr_q;
  logic [WID_W-1:0]  span;
  logic [IDX_W-1:0]  nbytes;
  logic [BYTE_SKIP_W-1:0] byte_skip;

  logic             load, rd_en, wr_en, update;
  logic [IDX_W-1:0] idx;
  logic [WIN_W-1:0] win, new_win;
  logic [FLD_W-1:0] res_c;
  logic             neg_c, zero_c;
  logic [FLD_W-1:0] result_q;
  logic             n_q, z_q;

  generate
    if (OFS_W > 3) begin : g_skip
      assign byte_skip = bit_offset[OFS_W-1:3];
    end else begin : g_noskip
      assign byte_skip = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      bitoff_q <= '0;
      wid_q    <= '0;
      op_q     <= OP_TEST;
      src_q    <= '0;
    end else if (load) begin
      addr_q   <= base_addr + ADDR_W'(byte_skip);
      bitoff_q <= bit_offset[POS_W-1:0];
      wid_q    <= (width_code == 5'd0) ? WID_W'(FLD_W) : {1'b0, width_code};
      op_q     <= bf_op_e'(op_sel);
      src_q    <= src_data;
    end
  end

  assign op_wr_q = op_writes(op_q);
  assign span    = WID_W'(bitoff_q) + wid_q + WID_W'(7);
  assign nbytes  = span[WID_W-1:3];

  bfe_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .nbytes (nbytes),
    .writes (op_wr_q),
    .load   (load),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .update (update),
    .done   (done),
    .busy   (busy),
    .idx    (idx)
  );

  bfe_window u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (load),
    .cap_en  (rd_en),
    .upd_en  (update),
    .idx     (idx),
    .rbyte   (mem_rdata),
    .new_win (new_win),
    .win     (win),
    .wbyte   (mem_wdata)
  );

  bfe_alu u_alu (
    .win     (win),
    .bitoff  (bitoff_q),
    .wid     (wid_q),
    .op      (op_q),
    .src     (src_q),
    .new_win (new_win),
    .res     (res_c),
    .neg     (neg_c),
    .zero    (zero_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      n_q      <= 1'b0;
      z_q      <= 1'b0;
    end else if (update) begin
      result_q <= res_c;
      n_q      <= neg_c;
      z_q      <= zero_c;
    end
  end

  assign mem_addr = addr_q + ADDR_W'(idx);
  assign mem_rd   = rd_en;
  assign mem_wr   = wr_en;
  assign result   = result_q;
  assign flag_n   = n_q;
  assign flag_z   = z_q;
endmodule

// File: rtl/bfe_checker.sv
module bfe_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wr_allowed
);
  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: done only arrives while the engine is still busy
  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R11: no memory traffic while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));

  // R1: back-to-back reads walk upward by one byte
  a_r1_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  // R1: back-to-back writes walk upward by one byte
  a_r1_write_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  // R9: write strobe only for modifying operations
  a_r9_no_write_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> wr_allowed);

  // R7: read and write strobes never overlap
  a_r7_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

bind bitfield_rmw_engine bfe_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_addr   (mem_addr),
  .wr_allowed (op_wr_q)
);

// File: tb/tb_bitfield_rmw_engine.sv
module tb_bitfield_rmw_engine;
  localparam int ADDR_W = 16;
  localparam int OFS_W  = 8;
  localparam int MEM_N  = 512;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [2:0]        op_sel;
  logic [ADDR_W-1:0] base_addr;
  logic [OFS_W-1:0]  bit_offset;
  logic [4:0]        width_code;
  logic [31:0]       src_data;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rd, mem_wr;
  logic [7:0]        mem_wdata, mem_rdata;
  logic              busy, done;
  logic [31:0]       result;
  logic              flag_n, flag_z;

  logic [7:0] mem     [MEM_N];
  logic [7:0] exp_mem [MEM_N];

  int n_checks = 0;
  int n_fail   = 0;
  int rd_cnt, wr_cnt, wr_order_bad, cycles;
  logic [ADDR_W-1:0] first_rd_addr, first_wr_addr;

  bitfield_rmw_engine #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .base_addr(base_addr), .bit_offset(bit_offset), .width_code(width_code),
    .src_data(src_data), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .result(result), .flag_n(flag_n), .flag_z(flag_z)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr[8:0]];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if (mem_rd) begin
        if (rd_cnt == 0) first_rd_addr = mem_addr;
        rd_cnt = rd_cnt + 1;
      end
      if (mem_wr) begin
        if (wr_cnt == 0) first_wr_addr = mem_addr;
        if (mem_addr != first_rd_addr + ADDR_W'(wr_cnt)) wr_order_bad = wr_order_bad + 1;
        mem[mem_addr[8:0]] <= mem_wdata;
        wr_cnt = wr_cnt + 1;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent bit-level model of the requirements
  logic [31:0] m_res;
  logic        m_n, m_z;
  int          m_nbytes;
  logic [ADDR_W-1:0] m_first;

  task automatic model(input int base, input int ofs, input int wcode,
                       input int op, input logic [31:0] src);
    int w, bo, ffo;
    logic [63:0] v;
    w  = (wcode == 0) ? 32 : wcode;
    bo = ofs % 8;
    v  = '0;
    ffo = -1;
    for (int a = 0; a < MEM_N; a++) exp_mem[a] = mem[a];
    for (int j = 0; j < w; j++) begin
      int p, byt, bit_i;
      p = ofs + j;
      byt = base + p / 8;
      bit_i = 7 - (p % 8);
      v = {v[62:0], mem[byt][bit_i]};
      if (ffo < 0 && mem[byt][bit_i]) ffo = j;
      case (op)
        2: exp_mem[byt][bit_i] = ~mem[byt][bit_i];
        4: exp_mem[byt][bit_i] = 1'b0;
        6: exp_mem[byt][bit_i] = 1'b1;
        7: exp_mem[byt][bit_i] = src[w-1-j];
        default: ;
      endcase
    end
    m_n = v[w-1];
    m_z = (v == 0);
    if (ffo < 0) ffo = w;
    case (op)
      1: m_res = v[31:0];
      3: m_res = (v[w-1] && w < 32) ? (v[31:0] | ~((32'd1 << w) - 32'd1)) : v[31:0];
      5: m_res = 32'(bo + ffo);
      default: m_res = 32'd0;
    endcase
    m_nbytes = (bo + w + 7) / 8;
    m_first  = ADDR_W'(base + ofs / 8);
  endtask

  task automatic run_op(input int base, input int ofs, input int wcode, input int op,
                        input logic [31:0] src, input bit intrude);
    int busy_drop, guard, mem_bad;
    bit is_wr;
    model(base, ofs, wcode, op, src);
    is_wr = (op == 2) || (op == 4) || (op == 6) || (op == 7);
    rd_cnt = 0; wr_cnt = 0; wr_order_bad = 0;
    busy_drop = 0; guard = 0;
    @(negedge clk);
    start = 1'b1; op_sel = 3'(op); base_addr = ADDR_W'(base);
    bit_offset = OFS_W'(ofs); width_code = 5'(wcode); src_data = src;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      @(negedge clk);
      start = 1'b1; op_sel = 3'd6; base_addr = ADDR_W'(base + 40);
      bit_offset = 8'd3; width_code = 5'd9; src_data = ~src;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && guard < 100) begin
      if (!busy) busy_drop++;
      @(negedge clk);
      guard++;
    end
    chk(guard < 100, "R10 done timeout", 64'(guard), 64'd0);
    chk(busy_drop == 0 && busy, "R10 busy held", 64'(busy_drop), 64'd0);
    chk(result == m_res, intrude ? "R10 result after ignored start" :
        (op == 1 ? "R3 extract unsigned" : op == 3 ? "R4 extract signed" :
         op == 5 ? "R5 find first one" : "R9 result zero"), 64'(result), 64'(m_res));
    chk({flag_n, flag_z} == {m_n, m_z}, "R6 flags", 64'({flag_n, flag_z}), 64'({m_n, m_z}));
    chk(rd_cnt == m_nbytes, "R2 read byte count", 64'(rd_cnt), 64'(m_nbytes));
    chk(first_rd_addr == m_first, "R1 first address", 64'(first_rd_addr), 64'(m_first));
    if (is_wr) begin
      chk(wr_cnt == m_nbytes && wr_order_bad == 0, "R7 write-back bytes and order",
          64'(wr_cnt), 64'(m_nbytes));
    end else begin
      chk(wr_cnt == 0, "R9 no write on read-only op", 64'(wr_cnt), 64'd0);
    end
    @(negedge clk);
    chk(!done && !busy, "R10 done single pulse", 64'({done, busy}), 64'd0);
    mem_bad = 0;
    for (int a = 0; a < MEM_N; a++) if (mem[a] !== exp_mem[a]) mem_bad++;
    chk(mem_bad == 0, op == 7 ? "R8 insert memory image" : "R7 memory image",
        64'(mem_bad), 64'd0);
  endtask

  initial begin
    cycles = 0;
    void'($urandom(32'd20240611));
    for (int a = 0; a < MEM_N; a++) mem[a] = 8'($urandom);
    rd_cnt = 0; wr_cnt = 0; wr_order_bad = 0;
    first_rd_addr = '0; first_wr_addr = '0;
    start = 0; op_sel = 0; base_addr = 0; bit_offset = 0; width_code = 0; src_data = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R11 reset state",
        64'({busy, done, mem_rd, mem_wr}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    run_op(10, 0, 0, 1, 32'h0, 0);                  // R3 full width, 4 bytes
    run_op(20, 7, 0, 1, 32'h0, 0);                  // R2 five bytes
    run_op(30, 7, 0, 7, 32'hA5C3_0F96, 0);          // R8 insert full width, 5 bytes
    run_op(40, 255, 1, 3, 32'h0, 0);                // R1 large offset, width 1
    run_op(50, 5, 3, 6, 32'h0, 0);                  // R7 ends on byte boundary
    mem[60] = 8'h00; mem[61] = 8'h00; mem[62] = 8'h00;
    run_op(60, 2, 12, 5, 32'h0, 0);                 // R5 all-zero field
    run_op(60, 2, 12, 0, 32'h0, 0);                 // R6 zero flag
    mem[70] = 8'h7F;
    run_op(70, 1, 4, 3, 32'h0, 0);                  // R4 negative field
    run_op(80, 4, 20, 2, 32'h0, 0);                 // R7 invert
    run_op(90, 3, 17, 4, 32'h0, 0);                 // R7 clear
    run_op(100, 6, 9, 7, 32'hFFFF_FFFF, 0);         // R8 extra source bits dropped
    run_op(110, 9, 13, 1, 32'h0, 1);                // R10 start while busy

    for (int k = 0; k < 300; k++) begin
      run_op(int'($urandom % 256), int'($urandom % 256), int'($urandom % 32),
             int'($urandom % 8), $urandom, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    n_checks++;
    n_fail++;
    $display("FAIL R10 watchdog expired actual=%0d expected=0", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule